// File: doc/BRIEF.md
# Serial Output Frame Assembler for a Two-Wire Audio Codec Link

This block sits on the controller side of a serial audio codec link and produces the outbound stream. It is clocked by the link's bit clock and repeats a fixed 256-bit frame. Each frame opens with a 16-bit tag slot. Twelve 20-bit slots follow it. The block drives a frame marker (`sync_o`) that is high during the tag slot, and a serial data line (`sdout_o`) that sends every slot most significant bit first.

The controller offers one codec register access at a time: a read/write flag, a 7-bit register index, 16 bits of write data and a 2-bit codec selector. The block samples the request only at a frame boundary. It places the access in slots 1 and 2 and encodes the tag slot according to the target. A primary codec (selector 00) gets both command tags set. A secondary codec (selector 01, 10 or 11) gets its selector in the two low tag bits instead, with the frame-valid flag still set. Ten PCM sample inputs, each with its own valid flag, fill slots 3 to 12.

Once the frame that carries an access has been sent completely, the block acknowledges it with a one-cycle pulse.

Top module: `aclink_out_framer`

## Requirements
- R1: After reset the block repeats 256-bit frames. `sync_o` is high for the first 16 bit times of each frame and low for the other 240.
- R2: Frame bit 0 is tag bit 15. Tag bits follow in descending order, then slots 1 to 12 in ascending slot order, with each 20-bit slot sent bit 19 first.
- R3: Tag bit 15 (frame valid) is 1 exactly when the frame carries a register access or at least one PCM slot is valid. An idle frame is all zeros.
- R4: For an access with selector 00, tag bits 14 and 13 are both 1 and tag bits 1:0 are 00.
- R5: For an access with a nonzero selector, tag bits 14 and 13 are 0, tag bits 1:0 equal the selector, and tag bit 15 is 1.
- R6: Slot 1 carries the read flag in bit 19 (1 = read, 0 = write) and the register index in bits 18:12. All its other bits are 0, and the whole slot is 0 when no access is carried.
- R7: On a write, slot 2 carries the write data in bits 19:4 with bits 3:0 zero. On a read or with no access, slot 2 is all zeros and the data input is ignored.
- R8: PCM input k (k = 0..9) feeds slot k+3. Its valid flag appears as tag bit 12-k. A slot whose flag is 0 is sent as zeros whatever its data input holds. Tag bit 2 is always 0.
- R9: A request is sampled only when a new frame is loaded. A request held during the frame that carries the previous access is not taken for the frame that follows.
- R10: `req_ack_o` pulses high for exactly one bit clock, during the first bit of the frame that follows the frame carrying the access. At no other time is it high.
- R11: While reset is active, `sync_o`, `sdout_o` and `req_ack_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk_i | input | 1 | Bit clock; all outputs change on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Register access request pending |
| req_rd_i | input | 1 | 1 = read access, 0 = write access |
| req_addr_i | input | 7 | Register index |
| req_data_i | input | 16 | Write data |
| req_cid_i | input | 2 | Target codec selector (00 = primary) |
| req_ack_o | output | 1 | One-cycle pulse after the access frame has been sent |
| pcm_vld_i | input | 10 | Valid flag per PCM slot (bit k for slot k+3) |
| pcm_data_i | input | 200 | PCM samples, slot k+3 in bits 20k+19:20k |
| sync_o | output | 1 | Frame marker, high during the tag slot |
| sdout_o | output | 1 | Serial frame data |

## Verification
The first rising edge after reset is released loads a frame. Every 256th edge after that loads another. `sync_o` and the first tag bit show up one edge after a load, and each later bit shows up one edge after the one before it. A request is therefore only seen at the end of the frame during which it was driven. Its data comes out in the next frame, and its acknowledge shows up in the frame after that, during the first bit. The bench writes new stimulus at the falling edge where a frame begins. It scores that frame one frame later, reading `sdout_o` on 256 consecutive falling edges. It checks the acknowledge at the first falling edge of each frame and confirms it has dropped at the second.

// File: rtl/aclink_out_pkg.sv
package aclink_out_pkg;
  localparam int TAG_W      = 16;
  localparam int SLOT_W     = 20;
  localparam int NUM_PCM    = 10;
  localparam int NUM_SLOTS  = NUM_PCM + 2;
  localparam int FRAME_BITS = TAG_W + SLOT_W * NUM_SLOTS;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int ADDR_W     = 7;
  localparam int DATA_W     = 16;
  localparam int CID_W      = 2;

  // Tag slot: valid, two command tags, one tag per PCM slot, zero, selector.
  function automatic logic [TAG_W-1:0] mk_tag(input logic cmd,
                                               input logic [CID_W-1:0] cid,
                                               input logic [NUM_PCM-1:0] pv);
    logic [TAG_W-1:0] t;
    t = '0;
    t[TAG_W-1] = cmd | (|pv);
    t[TAG_W-2] = cmd & (cid == '0);
    t[TAG_W-3] = cmd & (cid == '0);
    for (int k = 0; k < NUM_PCM; k++) t[TAG_W-4-k] = pv[k];
    if (cmd) t[CID_W-1:0] = cid;
    return t;
  endfunction

  function automatic logic [SLOT_W-1:0] mk_addr_slot(input logic cmd,
                                                     input logic rd,
                                                     input logic [ADDR_W-1:0] addr);
    logic [SLOT_W-1:0] s;
    s = '0;
    if (cmd) begin
      s[SLOT_W-1]          = rd;
      s[SLOT_W-2 -: ADDR_W] = addr;
    end
    return s;
  endfunction

  function automatic logic [SLOT_W-1:0] mk_data_slot(input logic cmd,
                                                     input logic rd,
                                                     input logic [DATA_W-1:0] data);
    logic [SLOT_W-1:0] s;
    s = '0;
    if (cmd && !rd) s[SLOT_W-1 -: DATA_W] = data;
    return s;
  endfunction
endpackage

// File: rtl/aclink_frame_timer.sv
module aclink_frame_timer
  import aclink_out_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [POS_W-1:0] pos_o,
  output logic             load_o,
  output logic             sync_o
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);
  localparam logic [POS_W-1:0] TAG_END  = POS_W'(TAG_W);

  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pos_q <= LAST_POS;
    else if (pos_q == LAST_POS) pos_q <= '0;
    else                      pos_q <= pos_q + 1'b1;
  end

  assign pos_o  = pos_q;
  assign load_o = (pos_q == LAST_POS);
  assign sync_o = rst_ni && (pos_q < TAG_END);

  AST_SYNC_RISES_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> (pos_q == '0)); // R1
  AST_SYNC_FALLS_AFTER_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sync_o) |-> (pos_q == TAG_END)); // R1
endmodule

// File: rtl/aclink_cmd_gate.sv
module aclink_cmd_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic req_valid_i,
  output logic take_o,
  output logic busy_o,
  output logic ack_o
);
  logic busy_q;
  logic ack_q;

  assign take_o = load_i && !busy_q && req_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      ack_q <= load_i && busy_q;
      if (load_i) busy_q <= take_o;
    end
  end

  assign busy_o = busy_q;
  assign ack_o  = ack_q;

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o); // R10
  AST_BUSY_ENDS_IN_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && busy_q |=> ack_o && !busy_q); // R9
  AST_ACK_NO_NEW_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !busy_q); // R9
endmodule

// File: rtl/aclink_frame_builder.sv
module aclink_frame_builder
  import aclink_out_pkg::*;
(
  input  logic                      cmd_i,
  input  logic                      rd_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         data_i,
  input  logic [CID_W-1:0]          cid_i,
  input  logic [NUM_PCM-1:0]        pcm_vld_i,
  input  logic [NUM_PCM*SLOT_W-1:0] pcm_data_i,
  output logic [FRAME_BITS-1:0]     frame_o
);
  localparam int SLOT1_TOP = FRAME_BITS - 1 - TAG_W;

  assign frame_o[FRAME_BITS-1 -: TAG_W]  = mk_tag(cmd_i, cid_i, pcm_vld_i);
  assign frame_o[SLOT1_TOP -: SLOT_W]    = mk_addr_slot(cmd_i, rd_i, addr_i);
  assign frame_o[SLOT1_TOP-SLOT_W -: SLOT_W] = mk_data_slot(cmd_i, rd_i, data_i);

  for (genvar k = 0; k < NUM_PCM; k++) begin : g_pcm
    assign frame_o[SLOT1_TOP - SLOT_W*(k+2) -: SLOT_W] =
      pcm_vld_i[k] ? pcm_data_i[k*SLOT_W +: SLOT_W] : '0;
  end
endmodule

// File: rtl/aclink_serializer.sv
module aclink_serializer
  import aclink_out_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  output logic                  sdout_o,
  output logic [TAG_W-1:0]      tag_view_o
);
  logic [FRAME_BITS-1:0] shreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shreg_q <= '0;
    else if (load_i) shreg_q <= frame_i;
    else             shreg_q <= {shreg_q[FRAME_BITS-2:0], 1'b0};
  end

  assign sdout_o    = shreg_q[FRAME_BITS-1];
  assign tag_view_o = shreg_q[FRAME_BITS-1 -: TAG_W];
endmodule

// File: rtl/aclink_out_framer.sv
module aclink_out_framer
  import aclink_out_pkg::*;
(
  input  logic                      bclk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  input  logic                      req_rd_i,
  input  logic [ADDR_W-1:0]         req_addr_i,
  input  logic [DATA_W-1:0]         req_data_i,
  input  logic [CID_W-1:0]          req_cid_i,
  output logic                      req_ack_o,
  input  logic [NUM_PCM-1:0]        pcm_vld_i,
  input  logic [NUM_PCM*SLOT_W-1:0] pcm_data_i,
  output logic                      sync_o,
  output logic                      sdout_o
);
  logic [POS_W-1:0]      frame_pos;
  logic                  frame_load;
  logic                  cmd_take;
  logic                  cmd_busy;
  logic [FRAME_BITS-1:0] next_frame;
  logic [TAG_W-1:0]      tag_view;

  aclink_frame_timer u_timer (
    .clk_i  (bclk_i),
    .rst_ni (rst_ni),
    .pos_o  (frame_pos),
    .load_o (frame_load),
    .sync_o (sync_o)
  );

  aclink_cmd_gate u_gate (
    .clk_i       (bclk_i),
    .rst_ni      (rst_ni),
    .load_i      (frame_load),
    .req_valid_i (req_valid_i),
    .take_o      (cmd_take),
    .busy_o      (cmd_busy),
    .ack_o       (req_ack_o)
  );

  aclink_frame_builder u_build (
    .cmd_i      (cmd_take),
    .rd_i       (req_rd_i),
    .addr_i     (req_addr_i),
    .data_i     (req_data_i),
    .cid_i      (req_cid_i),
    .pcm_vld_i  (pcm_vld_i),
    .pcm_data_i (pcm_data_i),
    .frame_o    (next_frame)
  );

  aclink_serializer u_ser (
    .clk_i      (bclk_i),
    .rst_ni     (rst_ni),
    .load_i     (frame_load),
    .frame_i    (next_frame),
    .sdout_o    (sdout_o),
    .tag_view_o (tag_view)
  );

  AST_VALID_ON_FIRST_BIT: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    frame_load && cmd_take |=> sdout_o && sync_o && (frame_pos == '0)); // R3
  AST_PRIMARY_TAGS: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    frame_load && cmd_take && (req_cid_i == '0) |=>
      (tag_view[TAG_W-2 -: 2] == 2'b11) && (tag_view[CID_W-1:0] == '0)); // R4
  AST_SECONDARY_TAGS: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    frame_load && cmd_take && (req_cid_i != '0) |=>
      tag_view[TAG_W-1] && (tag_view[TAG_W-2 -: 2] == 2'b00) &&
      (tag_view[CID_W-1:0] == $past(req_cid_i))); // R5
  AST_ACK_AT_FRAME_START: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    req_ack_o |-> (frame_pos == '0) && !cmd_busy); // R10
endmodule

// File: tb/aclink_out_framer_tb_top.sv
`timescale 1ns/1ps
module aclink_out_framer_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, req_rd;
  logic [6:0]   req_addr;
  logic [15:0]  req_data;
  logic [1:0]   req_cid;
  logic         req_ack;
  logic [9:0]   pcm_vld;
  logic [199:0] pcm_data;
  logic         sync, sdout;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  logic [255:0] exp_q[$];
  bit           cmd_q[$];
  bit           last_push_cmd;

  always #2.5 clk = ~clk;

  aclink_out_framer dut_i (
    .bclk_i      (clk),
    .rst_ni      (rst_n),
    .req_valid_i (req_valid),
    .req_rd_i    (req_rd),
    .req_addr_i  (req_addr),
    .req_data_i  (req_data),
    .req_cid_i   (req_cid),
    .req_ack_o   (req_ack),
    .pcm_vld_i   (pcm_vld),
    .pcm_data_i  (pcm_data),
    .sync_o      (sync),
    .sdout_o     (sdout)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [255:0] exp_frame(input bit cmd, input bit rd,
      input logic [6:0] a, input logic [15:0] d, input logic [1:0] cid,
      input logic [9:0] pv, input logic [199:0] pd);
    logic [15:0]  t;
    logic [19:0]  s [12];
    logic [255:0] r;
    t = 16'h0;
    t[15] = cmd || (pv != 10'h0);
    if (cmd && cid == 2'b00) begin t[14] = 1'b1; t[13] = 1'b1; end
    for (int k = 0; k < 10; k++) t[12-k] = pv[k];
    if (cmd) t[1:0] = cid;
    for (int n = 0; n < 12; n++) s[n] = 20'h0;
    if (cmd) s[0] = {rd, a, 12'h000};
    if (cmd && !rd) s[1] = {d, 4'h0};
    for (int k = 0; k < 10; k++) if (pv[k]) s[k+2] = pd[k*20 +: 20];
    r = 256'(t);
    for (int n = 0; n < 12; n++) r = (r << 20) | 256'(s[n]);
    return r;
  endfunction

  function automatic logic [199:0] pcm_pattern(input logic [19:0] seed);
    logic [199:0] p;
    for (int k = 0; k < 10; k++) p[k*20 +: 20] = seed ^ (20'h11111 * 20'(k + 1));
    return p;
  endfunction

  // Driver: sets the inputs for the frame that loads next and queues its expected image.
  task automatic apply_step(input int s);
    bit v = 1'b0, r = 1'b0, take;
    logic [6:0]   a  = 7'h0;
    logic [15:0]  d  = 16'h0;
    logic [1:0]   c  = 2'b00;
    logic [9:0]   pv = 10'h0;
    logic [199:0] pd = 200'h0;
    case (s)
      0: begin v = 1; r = 0; a = 7'h02; d = 16'h8080; c = 2'b00; end        // primary write
      1: begin v = 1; r = 1; a = 7'h7C; c = 2'b01; pv = 10'b00_0000_0011;    // held while busy
               pd = pcm_pattern(20'hABCDE); end
      2: begin v = 1; r = 1; a = 7'h7C; c = 2'b01; end                       // secondary read
      3: begin end                                                           // idle
      4: begin v = 1; r = 0; a = 7'h55; d = 16'hA5C3; c = 2'b11;             // secondary write
               pv = 10'h3FF; pd = pcm_pattern(20'h13579); end
      5: begin pv = 10'b10_0000_0000; pd = {200{1'b1}}; end                  // only slot 12
      6: begin v = 1; r = 1; a = 7'h7F; d = 16'hFFFF; c = 2'b00; end        // primary read
      default: begin end
    endcase
    req_valid = v; req_rd = r; req_addr = a; req_data = d; req_cid = c;
    pcm_vld = pv; pcm_data = pd;
    take = v && !last_push_cmd;
    last_push_cmd = take;
    exp_q.push_back(exp_frame(take, r, a, d, c, pv, pd));
    cmd_q.push_back(take);
  endtask

  string frame_req [9] = '{"R3 idle after reset", "R2/R4/R6/R7 primary write",
                           "R8/R9 held request skipped", "R5/R6 secondary read",
                           "R3 idle", "R5/R7/R8 secondary write full pcm",
                           "R8 single slot", "R4/R6/R7 primary read", "R3 idle"};

  // Monitor and scoreboard.
  initial begin
    logic [255:0] act, e;
    bit c, prev_cmd, sync_ok;
    rst_n = 1'b0; req_valid = 0; req_rd = 0; req_addr = 0; req_data = 0;
    req_cid = 0; pcm_vld = 0; pcm_data = 0;
    last_push_cmd = 1'b0;
    exp_q.push_back(256'h0);
    cmd_q.push_back(1'b0);
    repeat (3) @(negedge clk);
    chk(sync == 1'b0, "R11", "sync in reset", 256'(sync), 256'h0);
    chk(sdout == 1'b0, "R11", "sdout in reset", 256'(sdout), 256'h0);
    chk(req_ack == 1'b0, "R11", "ack in reset", 256'(req_ack), 256'h0);
    rst_n = 1'b1;
    do @(negedge clk); while (sync !== 1'b1);
    prev_cmd = 1'b0;
    for (int f = 0; f < 9; f++) begin
      if (f > 0) @(negedge clk);
      chk(req_ack == prev_cmd, "R10", "ack at frame start", 256'(req_ack), 256'(prev_cmd));
      e = exp_q.pop_front();
      c = cmd_q.pop_front();
      if (f < 8) apply_step(f);
      act = 256'h0;
      sync_ok = 1'b1;
      for (int i = 0; i < 256; i++) begin
        if (i > 0) @(negedge clk);
        act[255-i] = sdout;
        if (sync !== (i < 16)) sync_ok = 1'b0;
        if (i == 1) chk(req_ack == 1'b0, "R10", "ack drops after one cycle", 256'(req_ack), 256'h0);
      end
      chk(sync_ok, "R1", "sync high for tag slot only", 256'(sync_ok), 256'h1);
      chk(act === e, frame_req[f], "frame image", act, e);
      prev_cmd = c;
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule